// File: doc/BRIEF.md
# Dual-Capture 16-bit Timer Counter

This block is a 16-bit up counter. It can count rising edges of external pin A, or it can count one of three prescaler rates taken from the system clock. A compare register can clear the counter when the two are equal. Each time the counter meets the compare value on a counting step, the block gives a one-cycle match pulse.

Two capture registers take snapshots of the counter. The capture mode decides which events load them:
- rising edges of pins A and B;
- the rising and falling edge of pin A;
- the rising and falling edge of a timer flip-flop signal that comes from outside the block.

Because the two captures can be taken on opposite edges of one signal, software can get a pulse width by subtracting them. Software can also take a snapshot at any time by writing to the mode register. A separate interrupt pulse follows pin A on the edge that suits the capture mode.

Software sees two registers through a one-cycle write port: the mode register and the compare register. All three external inputs are asynchronous. Each passes through a two-flop synchronizer, and edges are found by comparing each synchronized sample with the one before it.

Top module: `dual_capture_timer`

## Requirements
- R1: After synchronous reset, cap0, cap1, ext_irq and match_pulse are 0. All mode fields are 0, so the count source is pin A, clear is off and hardware capture is off.
- R2: A mode write (wr_sel=0) stores wr_data[1:0] as the count source:
  - 00 counts synchronized rising edges of pin A;
  - 01 counts every clock;
  - 10 counts every 4th clock;
  - 11 counts every 16th clock.
- R3: When mode bit 2 is 1, a counting step that finds the counter equal to the compare register (written with wr_sel=1) sets the counter to 0. The counter therefore repeats every compare+1 steps.
- R4: When mode bit 2 is 0, a match never clears the counter. The counter wraps from 0xFFFF to 0, so with the every-clock source, match pulses come 65536 cycles apart.
- R5: match_pulse is high for exactly one cycle per counting step that finds the counter equal to the compare value. This holds whether clear is on or off, and also when the source ticks slowly.
- R6: With capture mode (mode bits 4:3) equal to 00, pin edges load neither capture register.
- R7: In capture mode 01, a rising edge of pin A loads cap0 and a rising edge of pin B loads cap1.
- R8: In capture mode 10, a rising edge of pin A loads cap0 and a falling edge of pin A loads cap1. A high pulse of N clocks therefore gives cap1-cap0 = N when counting every clock.
- R9: In capture mode 11, a rising edge of the timer flip-flop input loads cap0 and its falling edge loads cap1.
- R10: A mode write with wr_data[5]=0 copies the counter into cap0 on the write edge. A mode write with wr_data[5]=1 leaves cap0 unchanged.
- R11: ext_irq pulses for one cycle on a rising edge of pin A in capture modes 00, 01 and 11, and on a falling edge of pin A in capture mode 10.
- R12: When a capture and a count step fall on the same edge, the capture holds the count from before the step.
- R13: A pin change is seen on the third clock edge after it: the capture load, the ext_irq rise and the external count step all happen on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_sel | input | 1 | 0 selects the mode register, 1 selects the compare register |
| wr_data | input | 16 | Write data |
| pin_a | input | 1 | External input A (asynchronous) |
| pin_b | input | 1 | External input B (asynchronous) |
| tff_in | input | 1 | Timer flip-flop level from outside the block |
| cap0 | output | 16 | Capture register 0 |
| cap1 | output | 16 | Capture register 1 |
| ext_irq | output | 1 | Pin A edge interrupt pulse |
| match_pulse | output | 1 | Compare match pulse |

## Verification
Each result has a fixed latency:
- A pin change produces its capture load and its interrupt pulse on the third edge after it.
- A software capture lands on the edge of the mode write itself.
- A match pulse rises on the edge that follows the counting step that found equality.

The scoreboard records each expected interrupt with the exact cycle at which it is due. It flags any pulse that arrives early, late or without being expected.

Captures and match pulses are checked as differences or spacings: pulse widths from cap1-cap0, and counting rates from two software snapshots a known number of edges apart. This removes the unknown prescaler phase from every expected value. All checks sample on the falling edge, after the registered outputs have settled.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [1:0] {
    SRC_PIN_A = 2'b00,
    SRC_DIV1  = 2'b01,
    SRC_DIV4  = 2'b10,
    SRC_DIV16 = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    CAP_OFF      = 2'b00,
    CAP_A_B      = 2'b01,
    CAP_A_WIDTH  = 2'b10,
    CAP_FF_WIDTH = 2'b11
  } capm_e;

  // packed MSB first: capm at [4:3], clr_en at [2], src at [1:0]
  typedef struct packed {
    capm_e capm;
    logic  clr_en;
    src_e  src;
  } mode_t;

  localparam int MODE_W    = 5;
  localparam int SWCAP_BIT = 5;

  // synchronized input vector positions
  localparam int IN_A   = 0;
  localparam int IN_B   = 1;
  localparam int IN_FF  = 2;
  localparam int IN_NUM = 3;

endpackage

// File: rtl/dct_sync_edge.sv
module dct_sync_edge #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    // sh[STAGES-1] is the synchronized level, sh[STAGES] the previous sample
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-1:0], din[i]};
    end

    assign rise[i] = sh[STAGES-1] & ~sh[STAGES];
    assign fall[i] = ~sh[STAGES-1] & sh[STAGES];

    // R13: an edge reports a pin level sampled STAGES edges earlier
    a_r13_rise_latency: assert property (@(posedge clk) disable iff (rst)
      rise[i] |-> $past(din[i], STAGES));
    a_r13_fall_latency: assert property (@(posedge clk) disable iff (rst)
      fall[i] |-> !$past(din[i], STAGES));
  end

endmodule

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
  parameter int MID_LOG2 = 2,
  parameter int HI_LOG2  = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_mid,
  output logic tick_hi
);

  logic [HI_LOG2-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst) pre <= '0;
    else     pre <= pre + 1'b1;
  end

  assign tick_mid = &pre[MID_LOG2-1:0];
  assign tick_hi  = &pre;

  // R2: divided ticks never come on back-to-back cycles
  a_r2_mid_gap: assert property (@(posedge clk) disable iff (rst)
    tick_mid |=> !tick_mid);
  a_r2_hi_gap: assert property (@(posedge clk) disable iff (rst)
    tick_hi |=> !tick_hi);

endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clr_en,
  input  logic [W-1:0] cmp,
  output logic [W-1:0] cnt,
  output logic         match_pulse
);

  logic hit;
  assign hit = tick && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      match_pulse <= 1'b0;
    end else begin
      match_pulse <= hit;
      if (tick) begin
        if (hit && clr_en) cnt <= '0;
        else               cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: clear on match when enabled
  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == cmp && clr_en) |=> cnt == '0);
  // R4: wrap to zero from all ones
  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && (&cnt) && !(cnt == cmp && clr_en)) |=> cnt == '0);
  // R5: a match pulse always follows a counting step
  a_r5_after_tick: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> $past(tick));
  // R12: the count moves only on a step
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

endmodule

// File: rtl/dct_capture.sv
module dct_capture
  import dct_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  capm_e        capm,
  input  logic         sw_cap,
  input  logic         rise_a,
  input  logic         fall_a,
  input  logic         rise_b,
  input  logic         rise_f,
  input  logic         fall_f,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] cap0,
  output logic [W-1:0] cap1,
  output logic         ext_irq
);

  logic hw0, hw1, irq_ev;

  always_comb begin
    hw0    = 1'b0;
    hw1    = 1'b0;
    irq_ev = rise_a;
    unique case (capm)
      CAP_OFF: begin
        hw0 = 1'b0;
        hw1 = 1'b0;
      end
      CAP_A_B: begin
        hw0 = rise_a;
        hw1 = rise_b;
      end
      CAP_A_WIDTH: begin
        hw0    = rise_a;
        hw1    = fall_a;
        irq_ev = fall_a;
      end
      CAP_FF_WIDTH: begin
        hw0 = rise_f;
        hw1 = fall_f;
      end
      default: begin
        hw0 = 1'b0;
        hw1 = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap0    <= '0;
      cap1    <= '0;
      ext_irq <= 1'b0;
    end else begin
      if (sw_cap || hw0) cap0 <= cnt;
      if (hw1)           cap1 <= cnt;
      ext_irq <= irq_ev;
    end
  end

  // R6: disabled mode leaves both captures alone
  a_r6_off: assert property (@(posedge clk) disable iff (rst)
    (capm == CAP_OFF && !sw_cap) |=> ($stable(cap0) && $stable(cap1)));
  // R8: width mode loads cap1 on the falling edge of A
  a_r8_fall_load: assert property (@(posedge clk) disable iff (rst)
    (capm == CAP_A_WIDTH && fall_a) |=> cap1 == $past(cnt));
  // R9: flip-flop mode loads cap0 on its rising edge
  a_r9_ff_rise: assert property (@(posedge clk) disable iff (rst)
    (capm == CAP_FF_WIDTH && rise_f) |=> cap0 == $past(cnt));
  // R10: software capture takes the counter value
  a_r10_sw: assert property (@(posedge clk) disable iff (rst)
    sw_cap |=> cap0 == $past(cnt));
  // R11: interrupt edge follows the capture mode
  a_r11_irq_edge: assert property (@(posedge clk) disable iff (rst)
    ext_irq |-> $past((capm == CAP_A_WIDTH) ? fall_a : rise_a));

endmodule

// File: rtl/dual_capture_timer.sv
module dual_capture_timer
  import dct_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int DIV_MID_LOG2 = 2,
  parameter int DIV_HI_LOG2  = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             pin_a,
  input  logic             pin_b,
  input  logic             tff_in,
  output logic [CNT_W-1:0] cap0,
  output logic [CNT_W-1:0] cap1,
  output logic             ext_irq,
  output logic             match_pulse
);

  mode_t            mode_q;
  logic [CNT_W-1:0] cmp_q;
  logic             sw_cap;
  logic             tick;
  logic             tick_mid, tick_hi;
  logic [IN_NUM-1:0] pins, rise, fall;
  logic [CNT_W-1:0] cnt;

  // register write port
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      cmp_q  <= '0;
    end else if (wr_en) begin
      if (wr_sel) cmp_q  <= wr_data;
      else        mode_q <= mode_t'(wr_data[MODE_W-1:0]);
    end
  end

  assign sw_cap = wr_en && !wr_sel && !wr_data[SWCAP_BIT];

  assign pins[IN_A]  = pin_a;
  assign pins[IN_B]  = pin_b;
  assign pins[IN_FF] = tff_in;

  dct_sync_edge #(.W(IN_NUM), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pins),
    .rise(rise),
    .fall(fall)
  );

  dct_prescaler #(.MID_LOG2(DIV_MID_LOG2), .HI_LOG2(DIV_HI_LOG2)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .tick_mid(tick_mid),
    .tick_hi (tick_hi)
  );

  always_comb begin
    unique case (mode_q.src)
      SRC_PIN_A: tick = rise[IN_A];
      SRC_DIV1:  tick = 1'b1;
      SRC_DIV4:  tick = tick_mid;
      SRC_DIV16: tick = tick_hi;
      default:   tick = 1'b0;
    endcase
  end

  dct_counter #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .clr_en     (mode_q.clr_en),
    .cmp        (cmp_q),
    .cnt        (cnt),
    .match_pulse(match_pulse)
  );

  dct_capture #(.W(CNT_W)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .capm   (mode_q.capm),
    .sw_cap (sw_cap),
    .rise_a (rise[IN_A]),
    .fall_a (fall[IN_A]),
    .rise_b (rise[IN_B]),
    .rise_f (rise[IN_FF]),
    .fall_f (fall[IN_FF]),
    .cnt    (cnt),
    .cap0   (cap0),
    .cap1   (cap1),
    .ext_irq(ext_irq)
  );

  // R1: mode fields are cleared by reset
  a_r1_reset_mode: assert property (@(posedge clk)
    $past(rst) |-> (mode_q == '0 && cap0 == '0 && !ext_irq && !match_pulse));
  // R10: a mode write with the capture bit set leaves cap0 alone when hardware capture is off
  a_r10_write_one: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel && wr_data[SWCAP_BIT] && mode_q.capm == CAP_OFF) |=> $stable(cap0));

endmodule

// File: tb/dual_capture_timer_tb_top.sv
module dual_capture_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        pin_a = 1'b0;
  logic        pin_b = 1'b0;
  logic        tff_in = 1'b0;
  logic [15:0] cap0, cap1;
  logic        ext_irq, match_pulse;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  logic [4:0] mode_sh = '0;
  int irq_q[$];

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  dual_capture_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pin_a(pin_a), .pin_b(pin_b), .tff_in(tff_in),
    .cap0(cap0), .cap1(cap1), .ext_irq(ext_irq), .match_pulse(match_pulse)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (!sel) mode_sh = d[4:0];
  endtask

  // driver: pushes the cycle at which an interrupt is due (R11, R13)
  task automatic set_a(input logic v);
    if (v && !pin_a && mode_sh[4:3] != 2'b10) irq_q.push_back(cyc + 3);
    if (!v && pin_a && mode_sh[4:3] == 2'b10) irq_q.push_back(cyc + 3);
    pin_a = v;
  endtask

  task automatic wait_match(output int at);
    int t = 0;
    while (!match_pulse && t < 70000) begin
      @(negedge clk);
      t++;
    end
    if (!match_pulse) begin
      n_chk++; n_bad++;
      $display("FAIL R5 no match pulse got=0 exp=1");
    end
    at = cyc;
    @(negedge clk);
  endtask

  // monitor: compares interrupt pulses against the expected queue
  always @(negedge clk) begin
    if (!rst) begin
      if (ext_irq) begin
        n_chk++;
        if (irq_q.size() == 0 || irq_q[0] != cyc) begin
          n_bad++;
          $display("FAIL R11 irq at got=%0d exp=%0d", cyc,
                   (irq_q.size() != 0) ? irq_q[0] : -1);
        end
        if (irq_q.size() != 0) void'(irq_q.pop_front());
      end else if (irq_q.size() != 0 && irq_q[0] < cyc) begin
        n_chk++; n_bad++;
        $display("FAIL R13 irq missing got=%0d exp=%0d", cyc, irq_q[0]);
        void'(irq_q.pop_front());
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog got=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, d;
    int t1, t2;
    step(4);
    rst = 1'b0;
    step(1);
    // R1 reset state
    check("R1 cap0", cap0, 0);
    check("R1 cap1", cap1, 0);
    check("R1 irq", ext_irq, 0);
    check("R1 match", match_pulse, 0);

    // R12: count every clock, capture 4 edges later
    wr(0, 16'h0021);
    step(4);
    wr(0, 16'h0001);
    check("R12 pre-increment value", cap0, 4);

    // R6: capture off, pins do nothing to captures, irq still on A rise
    set_a(1); step(4); set_a(0); step(4);
    pin_b = 1; step(4); pin_b = 0; step(4);
    tff_in = 1; step(4); tff_in = 0; step(5);
    check("R6 cap0 kept", cap0, 4);
    check("R6 cap1 kept", cap1, 0);

    // R10: capture bit written as 1 has no effect
    wr(0, 16'h0021);
    step(2);
    check("R10 write one", cap0, 4);

    // R7: A rise then B rise 7 cycles apart
    wr(0, 16'h0029);
    set_a(1); step(7); pin_b = 1; step(5);
    d = cap1 - cap0;
    check("R7 a-to-b", d, 7);
    set_a(0); pin_b = 0; step(5);

    // R8: high pulse of 13 on A, irq on fall
    wr(0, 16'h0031);
    set_a(1); step(13); set_a(0); step(5);
    d = cap1 - cap0;
    check("R8 width", d, 13);

    // R9: flip-flop pulse of 9; A rise gives irq only
    wr(0, 16'h0039);
    tff_in = 1; step(9); tff_in = 0; step(5);
    d = cap1 - cap0;
    check("R9 ff width", d, 9);
    set_a(1); step(5); set_a(0); step(5);
    d = cap1 - cap0;
    check("R9 A ignored", d, 9);

    // R2: every 4th and every 16th clock
    wr(0, 16'h0022);
    wr(0, 16'h0002); v = cap0;
    step(39);
    wr(0, 16'h0002); d = cap0 - v;
    check("R2 div4", d, 10);
    wr(0, 16'h0023);
    wr(0, 16'h0003); v = cap0;
    step(159);
    wr(0, 16'h0003); d = cap0 - v;
    check("R2 div16", d, 10);

    // R2, R13: external pin A edges
    wr(0, 16'h0020);
    step(4);
    wr(0, 16'h0000); v = cap0;
    for (int k = 0; k < 7; k++) begin
      set_a(1); step(3); set_a(0); step(3);
    end
    step(5);
    wr(0, 16'h0000); d = cap0 - v;
    check("R2 pin A count", d, 7);

    // R3: clear on match, period compare+1
    v = cap0;
    wr(1, v + 16'd30);
    wr(0, 16'h0025);
    wait_match(t1);
    wr(1, 16'd9);
    wait_match(t1);
    wait_match(t2);
    check("R3 period", t2 - t1, 10);
    check("R5 width tap1", match_pulse, 0);

    // R5: slow source, still one pulse per step
    wr(0, 16'h0027);
    wait_match(t1);
    check("R5 width div16", match_pulse, 0);
    wait_match(t2);
    check("R5 div16 period", t2 - t1, 160);

    // R4: no clear, wrap
    wr(0, 16'h0021);
    wr(0, 16'h0001); v = cap0;
    wr(1, v + 16'd20);
    wait_match(t1);
    wait_match(t2);
    check("R4 wrap period", t2 - t1, 65536);

    step(5);
    check("R11 irq queue empty", irq_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule